// File: doc/BRIEF.md
# Bus requester with subordinate wakeup sequencing

This block issues single read and write transfers on an APB-style bus to a subordinate whose clock can be switched off independently of the requester. Before any transfer it raises a wakeup line toward the subordinate. It opens the setup phase only once the subordinate is known to be clocked. That happens either when the subordinate acknowledges the wakeup, or after a fixed settle delay, depending on a build-time mode.

A local command port holds one command: an address, a write flag, write data and a start strobe. The block returns read data, an error flag and a one-cycle done pulse for every accepted command.

In handshake mode a wakeup that is never acknowledged ends in a timeout. The command then finishes with the error flag set and no bus activity. While further commands keep arriving before the current transfer ends, the wakeup line stays high and the transfers follow each other without a new wake phase.

Top module: `apb_wake_requester`

## Requirements
- R1: PSEL is never high while PWAKEUP is low, and every rise of PSEL comes at least one cycle after PWAKEUP rose.
- R2: A start strobe sampled while `cmd_ready` is high and the requester is idle makes PWAKEUP high from the second rising clock edge after that sample.
- R3: With HANDSHAKE=1, PSEL rises on the first clock edge at which `wake_ack` is sampled high while the requester waits in the wake phase. If `wake_ack` goes high L cycles after PWAKEUP rises, the gap between the two rises is L cycles.
- R4: With HANDSHAKE=0, PSEL rises exactly WAKE_DLY cycles after PWAKEUP rises, and `wake_ack` has no effect on that timing.
- R5: PWAKEUP is low after reset and stays low while no command is held or in progress. After the last transfer completes, PWAKEUP is low from the completing clock edge on.
- R6: Each transfer spends one cycle with PSEL=1 and PENABLE=0, then holds PSEL=1 and PENABLE=1 until PREADY is sampled high. PADDR, PWRITE and PWDATA do not change from the setup cycle through the completing cycle.
- R7: If a new command is held when a transfer completes, the next cycle is its setup cycle. PSEL and PWAKEUP stay high throughout, and the pair of transfers produces one single rise of PWAKEUP.
- R8: With HANDSHAKE=1, if `wake_ack` is not sampled high within ACK_TIMEOUT cycles of PWAKEUP rising, the command ends with `rsp_done` and `rsp_err` high, PSEL never rises, and PWAKEUP drops. An acknowledge sampled on the last allowed edge still wins over the timeout.
- R9: `rsp_done` pulses for one cycle after the completing edge, and `rsp_err` equals PSLVERR sampled on that edge. A completing read loads PRDATA into `rsp_rdata`, while a write leaves `rsp_rdata` unchanged.
- R10: `cmd_ready` is low while a command is held and not yet issued, and a start strobe sampled while `cmd_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Requester clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_ready | output | 1 | Command slot is free |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error of the finished command (subordinate error or wake timeout) |
| rsp_rdata | output | DATA_W | Data of the last completed read |
| psel | output | 1 | Subordinate select |
| penable | output | 1 | Access phase indicator |
| pwrite | output | 1 | Transfer direction |
| paddr | output | ADDR_W | Transfer address |
| pwdata | output | DATA_W | Transfer write data |
| prdata | input | DATA_W | Subordinate read data |
| pready | input | 1 | Subordinate completes the access |
| pslverr | input | 1 | Subordinate error |
| pwakeup | output | 1 | Wake request to the subordinate clock control |
| wake_ack | input | 1 | Subordinate reports its clock running (handshake mode) |

## Verification
Two events can land on the same edge: the wake acknowledge and the expiry of the wake timeout. The bench sets the acknowledge latency of its subordinate model to exactly ACK_TIMEOUT cycles and then to one cycle more. The first run must produce a normal transfer with the setup phase ACK_TIMEOUT cycles after the wakeup, and the second must produce an error completion with no select. A second collision comes from a new command being held when the current transfer completes. It is judged by requiring the next setup phase in the very cycle after completion, with the wakeup still high.

// File: rtl/arw_pkg.sv
package arw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ACCESS = 2'd3
  } arw_state_e;
endpackage

// File: rtl/arw_cmd_slot.sv
// One-entry command holding register between the local port and the sequencer.
module arw_cmd_slot #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              ready,
  output logic              valid,
  output logic              q_write,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      q_write <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (take) begin
      valid <= 1'b0;
    end else if (start && !valid) begin
      valid   <= 1'b1;
      q_write <= write;
      q_addr  <= addr;
      q_wdata <= wdata;
    end
  end

  assign ready = !valid;

  // R10: a held command is neither lost nor overwritten until it is taken
  assert_hold_while_full_R10: assert property (@(posedge clk) disable iff (rst)
    (valid && !take) |=> (valid && $stable(q_addr) && $stable(q_write) && $stable(q_wdata)));
endmodule

// File: rtl/arw_wake_timer.sv
// Counts cycles spent in the wake phase; flags settle delay and ack timeout.
module arw_wake_timer #(
  parameter int WAKE_DLY    = 4,
  parameter int ACK_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic dly_hit,
  output logic to_hit
);
  localparam int LIM = (WAKE_DLY > ACK_TIMEOUT) ? WAKE_DLY : ACK_TIMEOUT;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)            cnt <= '0;
    else if (cnt != CW'(LIM))   cnt <= cnt + 1'b1;
  end

  assign dly_hit = run && (cnt == CW'(WAKE_DLY - 1));
  assign to_hit  = run && (cnt == CW'(ACK_TIMEOUT - 1));
endmodule

// File: rtl/apb_wake_requester.sv
module apb_wake_requester #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int HANDSHAKE   = 1,
  parameter int WAKE_DLY    = 4,
  parameter int ACK_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr,
  output logic              pwakeup,
  input  logic              wake_ack
);
  import arw_pkg::*;

  arw_state_e        state;
  logic              slot_v, slot_write, take;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_wdata;
  logic              dly_hit, to_hit;
  logic              wake_ok, wake_fail, go_setup;

  arw_cmd_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst(rst), .start(cmd_start), .write(cmd_write),
    .addr(cmd_addr), .wdata(cmd_wdata), .take(take), .ready(cmd_ready),
    .valid(slot_v), .q_write(slot_write), .q_addr(slot_addr), .q_wdata(slot_wdata)
  );

  arw_wake_timer #(.WAKE_DLY(WAKE_DLY), .ACK_TIMEOUT(ACK_TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAKE),
    .dly_hit(dly_hit), .to_hit(to_hit)
  );

  // Wake exit condition chosen by build-time mode
  assign wake_ok   = (HANDSHAKE != 0) ? wake_ack : dly_hit;
  assign wake_fail = (HANDSHAKE != 0) && to_hit && !wake_ack;

  always_comb begin
    go_setup = 1'b0;
    if (state == ST_WAKE && wake_ok)                 go_setup = 1'b1;
    if (state == ST_ACCESS && pready && slot_v)      go_setup = 1'b1;
  end
  assign take = go_setup || (state == ST_WAKE && wake_fail);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      psel      <= 1'b0;
      penable   <= 1'b0;
      pwrite    <= 1'b0;
      paddr     <= '0;
      pwdata    <= '0;
      pwakeup   <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (go_setup) begin
        state   <= ST_SETUP;
        psel    <= 1'b1;
        penable <= 1'b0;
        pwrite  <= slot_write;
        paddr   <= slot_addr;
        pwdata  <= slot_wdata;
      end
      case (state)
        ST_IDLE: begin
          if (slot_v) begin
            state   <= ST_WAKE;
            pwakeup <= 1'b1;
          end
        end
        ST_WAKE: begin
          if (!go_setup && wake_fail) begin
            state    <= ST_IDLE;
            pwakeup  <= 1'b0;
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
          end
        end
        ST_SETUP: begin
          state   <= ST_ACCESS;
          penable <= 1'b1;
        end
        ST_ACCESS: begin
          if (pready) begin
            rsp_done <= 1'b1;
            rsp_err  <= pslverr;
            if (!pwrite) rsp_rdata <= prdata;
            if (!slot_v) begin
              state   <= ST_IDLE;
              psel    <= 1'b0;
              penable <= 1'b0;
              pwakeup <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: select only ever appears on an already woken subordinate
  assert_sel_needs_wake_R1: assert property (@(posedge clk) disable iff (rst)
    psel |-> pwakeup);
  assert_wake_before_sel_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(psel) |-> $past(pwakeup));
  // R5: wakeup is raised only for a held command
  assert_wake_has_work_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwakeup) |-> $past(slot_v));
  // R6: setup lasts one cycle and is followed by access
  assert_setup_to_access_R6: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));
  // R9: completion pulse never lasts two cycles
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/tb_apb_wake_requester.sv
module tb_apb_wake_requester;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TO = 64;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // handshake-mode instance
  logic          cmd_start = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, rsp_done, rsp_err, psel, penable, pwrite, pwakeup;
  logic [DW-1:0] rsp_rdata, pwdata, prdata;
  logic [AW-1:0] paddr;
  logic          pready = 0, pslverr, wake_ack = 0;

  apb_wake_requester #(.ADDR_W(AW), .DATA_W(DW), .HANDSHAKE(1), .WAKE_DLY(DLY), .ACK_TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr), .pwakeup(pwakeup),
    .wake_ack(wake_ack));

  // delay-mode instance
  logic          d_start = 0, d_ack = 0;
  logic          d_ready, d_done, d_err, d_psel, d_penable, d_pwrite, d_pwakeup;
  logic [DW-1:0] d_rdata, d_pwdata;
  logic [AW-1:0] d_paddr;

  apb_wake_requester #(.ADDR_W(AW), .DATA_W(DW), .HANDSHAKE(0), .WAKE_DLY(DLY), .ACK_TIMEOUT(TO)) dut_d (
    .clk(clk), .rst(rst), .cmd_start(d_start), .cmd_write(1'b1), .cmd_addr(16'h0042),
    .cmd_wdata(32'h5), .cmd_ready(d_ready), .rsp_done(d_done), .rsp_err(d_err),
    .rsp_rdata(d_rdata), .psel(d_psel), .penable(d_penable), .pwrite(d_pwrite), .paddr(d_paddr),
    .pwdata(d_pwdata), .prdata(32'h0), .pready(1'b1), .pslverr(1'b0), .pwakeup(d_pwakeup),
    .wake_ack(d_ack));

  // subordinate model: wait states, data derived from address, error at one address
  int waits = 0, wcnt = 0, ack_lat = 1, wk_cnt = 0;
  logic [AW-1:0] m_addr;
  logic          m_write;
  logic [DW-1:0] m_wdata;
  assign prdata  = {paddr, ~paddr};
  assign pslverr = (paddr == 16'hBAD0);

  always @(negedge clk) begin
    if (psel && penable) begin
      if (wcnt == waits) begin
        pready  = 1'b1;
        m_addr  = paddr;
        m_write = pwrite;
        m_wdata = pwdata;
      end else pready = 1'b0;
      wcnt = wcnt + 1;
    end else begin
      pready = 1'b0;
      wcnt = 0;
    end
    if (pwakeup) wk_cnt = wk_cnt + 1; else wk_cnt = 0;
    wake_ack = (wk_cnt >= ack_lat);
  end

  // observers
  int t_wake = 0, t_sel = 0, n_wake = 0, n_sel = 0, bad_stable = 0, bad_setup = 0;
  int d_t_wake = 0, d_t_sel = 0;
  logic prev_pw = 0, prev_sel = 0, d_prev_pw = 0, d_prev_sel = 0;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  always @(negedge clk) begin
    if (pwakeup && !prev_pw) begin t_wake = cyc; n_wake = n_wake + 1; end
    if (psel && !prev_sel) begin t_sel = cyc; n_sel = n_sel + 1; end
    if (psel && !prev_sel && penable) bad_setup = bad_setup + 1;
    if (psel && !penable) begin lat_addr = paddr; lat_wdata = pwdata; end
    if (psel && penable && (paddr != lat_addr || pwdata != lat_wdata)) bad_stable = bad_stable + 1;
    prev_pw = pwakeup; prev_sel = psel;
    if (d_pwakeup && !d_prev_pw) d_t_wake = cyc;
    if (d_psel && !d_prev_sel) d_t_sel = cyc;
    d_prev_pw = d_pwakeup; d_prev_sel = d_psel;
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, output int s);
    tick();
    cmd_start = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; s = cyc;
    tick();
    cmd_start = 0;
  endtask

  task automatic wait_done(output int c);
    c = -1;
    for (int i = 0; i < 300; i++) begin
      if (rsp_done) begin c = cyc; break; end
      tick();
    end
    chk(c >= 0, "R9 done pulse seen", c, 1);
  endtask

  task automatic t_reset();
    tick();
    chk(!psel && !penable, "R6 bus idle after reset", psel, 0);
    chk(!pwakeup, "R5 wakeup low after reset", pwakeup, 0);
    chk(cmd_ready, "R10 ready after reset", cmd_ready, 1);
    chk(!rsp_done, "R9 no done after reset", rsp_done, 0);
  endtask

  task automatic t_hs_read();
    int s, c;
    waits = 0; ack_lat = 3;
    issue(0, 16'h1234, '0, s);
    wait_done(c);
    chk(t_wake == s + 2, "R2 wakeup latency", t_wake, s + 2);
    chk(t_sel - t_wake == 3, "R3 ack latency 3", t_sel - t_wake, 3);
    chk(rsp_rdata == {16'h1234, 16'hEDCB}, "R9 read data", rsp_rdata, {16'h1234, 16'hEDCB});
    chk(!rsp_err, "R9 no error", rsp_err, 0);
    chk(!pwakeup, "R5 wakeup dropped after done", pwakeup, 0);
    chk(bad_setup == 0 && bad_stable == 0, "R6 phases and stability", bad_stable, 0);
  endtask

  task automatic t_write_err();
    int s, c;
    waits = 2; ack_lat = 1;
    issue(1, 16'hBAD0, 32'hCAFE0001, s);
    wait_done(c);
    chk(t_sel - t_wake == 1, "R3 ack latency 1", t_sel - t_wake, 1);
    chk(rsp_err, "R9 error passed", rsp_err, 1);
    chk(rsp_rdata == {16'h1234, 16'hEDCB}, "R9 write keeps rdata", rsp_rdata, {16'h1234, 16'hEDCB});
    chk(m_write && m_addr == 16'hBAD0 && m_wdata == 32'hCAFE0001, "R6 write seen on bus", m_wdata, 32'hCAFE0001);
    chk(bad_stable == 0, "R6 stable with waits", bad_stable, 0);
    chk(t_sel > t_wake, "R1 select after wakeup", t_sel, t_wake + 1);
  endtask

  task automatic t_b2b();
    int s, c, w0;
    waits = 3; ack_lat = 2; w0 = n_wake;
    issue(0, 16'h0100, '0, s);
    for (int i = 0; i < 50 && !psel; i++) tick();
    issue(1, 16'h0200, 32'h77, s);
    wait_done(c);
    chk(psel && !penable && paddr == 16'h0200, "R7 next setup right after done", paddr, 16'h0200);
    chk(pwakeup, "R7 wakeup held between transfers", pwakeup, 1);
    tick();
    wait_done(c);
    chk(n_wake - w0 == 1, "R7 single wakeup rise", n_wake - w0, 1);
    chk(!pwakeup, "R5 wakeup low after last", pwakeup, 0);
  endtask

  task automatic t_timeout(input int lat, input bit expect_ok);
    int s, c, n0;
    waits = 0; ack_lat = lat; n0 = n_sel;
    issue(0, 16'h0055, '0, s);
    wait_done(c);
    if (expect_ok) begin
      chk(!rsp_err, "R8 ack on last edge wins", rsp_err, 0);
      chk(t_sel - t_wake == TO, "R8 select at limit", t_sel - t_wake, TO);
    end else begin
      chk(rsp_err, "R8 timeout error", rsp_err, 1);
      chk(n_sel == n0, "R8 no select on timeout", n_sel - n0, 0);
      chk(c - t_wake == TO, "R8 timeout length", c - t_wake, TO);
      chk(!pwakeup, "R8 wakeup dropped", pwakeup, 0);
    end
    ack_lat = 1;
  endtask

  task automatic t_ready();
    int s, c, n0;
    waits = 0; ack_lat = 10;
    issue(0, 16'h0300, '0, s);
    chk(!cmd_ready, "R10 ready low while held", cmd_ready, 0);
    issue(0, 16'h0400, '0, s);
    wait_done(c);
    n0 = n_sel;
    for (int i = 0; i < 15; i++) tick();
    chk(n_sel == n0, "R10 ignored start gives no transfer", n_sel - n0, 0);
    chk(m_addr == 16'h0300, "R10 first command kept", m_addr, 16'h0300);
    chk(cmd_ready, "R10 ready again", cmd_ready, 1);
  endtask

  task automatic t_quiet();
    int n0 = n_wake;
    for (int i = 0; i < 20; i++) tick();
    chk(n_wake == n0 && !pwakeup, "R5 no wakeup without command", n_wake - n0, 0);
  endtask

  task automatic t_delay(input logic ackv);
    d_ack = ackv;
    tick(); d_start = 1; tick(); d_start = 0;
    for (int i = 0; i < 40 && !d_done; i++) tick();
    chk(d_done && !d_err, "R4 delay-mode transfer done", d_done, 1);
    chk(d_t_sel - d_t_wake == DLY, "R4 settle delay", d_t_sel - d_t_wake, DLY);
    d_ack = 0;
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_hs_read();
    t_write_err();
    t_b2b();
    t_timeout(TO, 1);
    t_timeout(TO + 1, 0);
    t_timeout(1000, 0);
    t_ready();
    t_quiet();
    t_delay(1'b0);
    t_delay(1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule